// File: doc/BRIEF.md
# Overflow Offset Merge Engine

This engine runs once the build phase has filled two things: a small memory of per-bucket overflow row counts, and an unsorted area of overflow rows in which each row carries its bucket index. A start pulse launches two passes. The first pass reads every bucket's count in ascending bucket order and forms an exclusive running sum. The result is the starting offset of each bucket in a compacted destination area, and it is loaded into a per-bucket write cursor. The sum over all buckets gives the total number of overflow rows.

The second pass reads the source rows in address order, 0 up to total-1. Each row is written to the destination at its bucket's current cursor, and that cursor then advances by one. The destination area ends up grouped by bucket, with each bucket's rows kept in their source order, ready for the probe phase. The source read port and the destination write port are separate and can both transfer in the same cycle. Each port can stall the engine with its own ready input. A one-cycle done pulse closes the run.

Top module: `ovf_merge_engine`

## Requirements
- R1: After reset, done, cnt_rd_en, src_rd_req and dst_wr_valid are all 0.
- R2: After start, the counter memory is read exactly once per bucket, at addresses 0 to NB-1 in ascending order and on consecutive cycles. The read data is taken one cycle after the read enable.
- R3: A bucket's first row is written to the destination address equal to the sum of the counts of all lower-numbered buckets, so bucket 0 starts at 0.
- R4: Rows of the same bucket go to consecutive ascending addresses in source order, including rows that arrive back to back.
- R5: The source area is read at addresses 0 to T-1 in ascending order, each exactly once, where T is the sum of all counts. Read data arrives one cycle after a read is accepted.
- R6: Each destination write carries the payload of the matching source row, and writes are issued in source order.
- R7: A source read and a destination write can be accepted in the same cycle.
- R8: While src_rd_req is high and src_rd_ready is low, the request and its address hold. While dst_wr_valid is high and dst_wr_ready is low, the write, its address and its data hold.
- R9: done is a one-cycle pulse that follows the last accepted write. When all counts are zero, done follows the counter pass and no source read or destination write occurs.
- R10: A start pulse while a run is in progress has no effect. The counter pass does not restart and only one done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| done | output | 1 | One-cycle completion pulse |
| cnt_rd_en | output | 1 | Counter memory read enable |
| cnt_rd_addr | output | $clog2(NB) | Bucket index to read |
| cnt_rd_data | input | CW | Overflow count, valid one cycle after the enable |
| src_rd_req | output | 1 | Source row read request |
| src_rd_addr | output | AW | Source row address |
| src_rd_ready | input | 1 | Source port accepts the request this cycle |
| src_rsp_valid | input | 1 | Source row returned (one cycle after acceptance) |
| src_rsp_bucket | input | $clog2(NB) | Bucket index of the returned row |
| src_rsp_data | input | DW | Payload of the returned row |
| dst_wr_valid | output | 1 | Destination write request |
| dst_wr_addr | output | AW | Destination address (bucket cursor) |
| dst_wr_data | output | DW | Row payload to write |
| dst_wr_ready | input | 1 | Destination port accepts the write this cycle |

## Verification
The bench builds the engine with NB=8 buckets, 5-bit counts, 8-bit addresses, 16-bit payloads and a two-entry return buffer. Eight buckets are few enough that the runs include an empty bucket inside the range, a long back-to-back run in one bucket, and the last bucket. The buffer of two entries is the smallest one that still allows one row per cycle. With it, independent pseudo-random stalls on both ports reach the credit limit and the hold conditions often, and an all-ready run shows reads and writes accepted in the same cycle.

// File: rtl/ovf_merge_pkg.sv
package ovf_merge_pkg;
  typedef enum logic [1:0] {
    MG_IDLE,
    MG_SCAN,
    MG_MOVE,
    MG_FIN
  } mg_state_e;
endpackage

// File: rtl/ovf_offset_scan.sv
module ovf_offset_scan #(
  parameter int NB = 16,
  parameter int CW = 8,
  parameter int AW = 10,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          cnt_rd_en,
  output logic [BW-1:0] cnt_rd_addr,
  input  logic [CW-1:0] cnt_rd_data,
  output logic          ld_en,
  output logic [BW-1:0] ld_idx,
  output logic [AW-1:0] ld_val,
  output logic          scan_done,
  output logic [AW-1:0] total
);
  localparam logic [BW:0]   LAST_ISSUE = (BW+1)'(NB);
  localparam logic [BW-1:0] LAST_IDX   = BW'(NB - 1);

  function automatic logic [AW-1:0] offset_step(input logic [AW-1:0] base,
                                                input logic [CW-1:0] cnt);
    return base + AW'(cnt);
  endfunction

  logic          busy;
  logic [BW:0]   issue_cnt;
  logic          pend;
  logic [BW-1:0] pend_idx;
  logic [AW-1:0] acc;

  assign cnt_rd_en   = busy && (issue_cnt != LAST_ISSUE);
  assign cnt_rd_addr = issue_cnt[BW-1:0];
  assign ld_en       = pend;
  assign ld_idx      = pend_idx;
  assign ld_val      = acc;
  assign scan_done   = pend && (pend_idx == LAST_IDX);
  assign total       = offset_step(acc, cnt_rd_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      issue_cnt <= '0;
      pend      <= 1'b0;
      pend_idx  <= '0;
      acc       <= '0;
    end else if (go) begin
      busy      <= 1'b1;
      issue_cnt <= '0;
      pend      <= 1'b0;
      acc       <= '0;
    end else begin
      pend <= cnt_rd_en;
      if (cnt_rd_en) begin
        pend_idx  <= issue_cnt[BW-1:0];
        issue_cnt <= issue_cnt + 1'b1;
      end
      if (pend) acc <= offset_step(acc, cnt_rd_data);
      if (scan_done) busy <= 1'b0;
    end
  end

  // R2: counter reads step through buckets one by one
  a_r2_scan_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd_en && $past(cnt_rd_en) |-> cnt_rd_addr == BW'($past(cnt_rd_addr) + 1'b1));

  // R2: the first read of a pass is bucket 0
  a_r2_scan_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_rd_en) |-> cnt_rd_addr == '0);
endmodule

// File: rtl/ovf_cursor_file.sv
module ovf_cursor_file #(
  parameter int NB = 16,
  parameter int AW = 10,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [BW-1:0] ld_idx,
  input  logic [AW-1:0] ld_val,
  input  logic          bump_en,
  input  logic [BW-1:0] bump_idx,
  input  logic [BW-1:0] rd_idx,
  output logic [AW-1:0] rd_val
);
  function automatic logic [AW-1:0] cursor_next(input logic [AW-1:0] c);
    return c + 1'b1;
  endfunction

  logic [AW-1:0] cur [NB];

  for (genvar g = 0; g < NB; g++) begin : g_cur
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cur[g] <= '0;
      else if (ld_en && (ld_idx == BW'(g)))
        cur[g] <= ld_val;
      else if (bump_en && (bump_idx == BW'(g)))
        cur[g] <= cursor_next(cur[g]);
    end
  end

  assign rd_val = cur[rd_idx];

  // R3: offset loading and cursor advance belong to different passes
  a_r3_no_load_bump_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_en && bump_en));
endmodule

// File: rtl/ovf_row_fifo.sv
module ovf_row_fifo #(
  parameter int W  = 16,
  parameter int FD = 2,
  localparam int PW   = (FD > 1) ? $clog2(FD) : 1,
  localparam int CNTW = $clog2(FD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic            not_empty,
  output logic [CNTW-1:0] count
);
  localparam logic [PW-1:0] LAST_SLOT = PW'(FD - 1);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  slot [FD];
  logic [PW-1:0] wp, rp;

  assign head      = slot[rp];
  assign not_empty = (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= ptr_next(wp);
      if (pop)  rp <= ptr_next(rp);
      count <= count + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= push_data;
  end

  // R8: read credit keeps the return buffer from overflowing
  a_r8_fifo_room: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> count < CNTW'(FD));

  a_r6_fifo_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/ovf_relocator.sv
module ovf_relocator #(
  parameter int NB = 16,
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int FD = 2,
  localparam int BW   = $clog2(NB),
  localparam int CNTW = $clog2(FD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] total_in,
  output logic          src_rd_req,
  output logic [AW-1:0] src_rd_addr,
  input  logic          src_rd_ready,
  input  logic          src_rsp_valid,
  input  logic [BW-1:0] src_rsp_bucket,
  input  logic [DW-1:0] src_rsp_data,
  output logic          wr_valid,
  output logic [BW-1:0] wr_bucket,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          rd_fire,
  output logic          wr_fire,
  output logic          moved_all
);
  function automatic logic credit_ok(input logic [CNTW-1:0] held,
                                     input logic inflight_i,
                                     input logic leaving);
    return ((CNTW+1)'(held) + (CNTW+1)'(inflight_i)) <
           ((CNTW+1)'(FD) + (CNTW+1)'(leaving));
  endfunction

  logic            active;
  logic [AW-1:0]   total_q;
  logic [AW-1:0]   issued;
  logic [AW-1:0]   written;
  logic            inflight;
  logic [CNTW-1:0] fcnt;
  logic            fnot_empty;
  logic [BW+DW-1:0] fhead;

  assign wr_valid    = active && fnot_empty;
  assign wr_bucket   = fhead[BW+DW-1:DW];
  assign wr_data     = fhead[DW-1:0];
  assign wr_fire     = wr_valid && wr_ready;
  assign src_rd_req  = active && (issued != total_q) && credit_ok(fcnt, inflight, wr_fire);
  assign src_rd_addr = issued;
  assign rd_fire     = src_rd_req && src_rd_ready;
  assign moved_all   = active && (written == total_q);

  ovf_row_fifo #(.W(BW + DW), .FD(FD)) u_ret_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (src_rsp_valid),
    .push_data ({src_rsp_bucket, src_rsp_data}),
    .pop       (wr_fire),
    .head      (fhead),
    .not_empty (fnot_empty),
    .count     (fcnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      total_q  <= '0;
      issued   <= '0;
      written  <= '0;
      inflight <= 1'b0;
    end else if (go) begin
      active   <= 1'b1;
      total_q  <= total_in;
      issued   <= '0;
      written  <= '0;
      inflight <= 1'b0;
    end else begin
      inflight <= rd_fire;
      if (rd_fire) issued  <= issued + 1'b1;
      if (wr_fire) written <= written + 1'b1;
      if (moved_all) active <= 1'b0;
    end
  end

  // R5: a returned row matches a read accepted the cycle before
  a_r5_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    src_rsp_valid |-> inflight);

  // R8: a stalled read request keeps its address
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_req && !src_rd_ready |=> src_rd_req && $stable(src_rd_addr));

  // R5: reads never pass the row total
  a_r5_no_overread: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> issued < total_q);
endmodule

// File: rtl/ovf_merge_engine.sv
module ovf_merge_engine
  import ovf_merge_pkg::*;
#(
  parameter int NB = 16,
  parameter int CW = 8,
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int FD = 2,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          cnt_rd_en,
  output logic [BW-1:0] cnt_rd_addr,
  input  logic [CW-1:0] cnt_rd_data,
  output logic          src_rd_req,
  output logic [AW-1:0] src_rd_addr,
  input  logic          src_rd_ready,
  input  logic          src_rsp_valid,
  input  logic [BW-1:0] src_rsp_bucket,
  input  logic [DW-1:0] src_rsp_data,
  output logic          dst_wr_valid,
  output logic [AW-1:0] dst_wr_addr,
  output logic [DW-1:0] dst_wr_data,
  input  logic          dst_wr_ready
);
  mg_state_e     state, state_nx;
  logic          scan_go, move_go;
  logic          scan_done;
  logic [AW-1:0] total;
  logic          ld_en;
  logic [BW-1:0] ld_idx;
  logic [AW-1:0] ld_val;
  logic [BW-1:0] wr_bucket;
  logic          rd_fire, wr_fire, moved_all;

  assign scan_go = (state == MG_IDLE) && start;
  assign move_go = (state == MG_SCAN) && scan_done && (total != '0);
  assign done    = (state == MG_FIN);

  always_comb begin
    state_nx = state;
    unique case (state)
      MG_IDLE: if (start) state_nx = MG_SCAN;
      MG_SCAN: if (scan_done) state_nx = (total == '0) ? MG_FIN : MG_MOVE;
      MG_MOVE: if (moved_all) state_nx = MG_FIN;
      MG_FIN:  state_nx = MG_IDLE;
      default: state_nx = MG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= MG_IDLE;
    else        state <= state_nx;
  end

  ovf_offset_scan #(.NB(NB), .CW(CW), .AW(AW)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (scan_go),
    .cnt_rd_en   (cnt_rd_en),
    .cnt_rd_addr (cnt_rd_addr),
    .cnt_rd_data (cnt_rd_data),
    .ld_en       (ld_en),
    .ld_idx      (ld_idx),
    .ld_val      (ld_val),
    .scan_done   (scan_done),
    .total       (total)
  );

  ovf_cursor_file #(.NB(NB), .AW(AW)) u_cursors (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_idx   (ld_idx),
    .ld_val   (ld_val),
    .bump_en  (wr_fire),
    .bump_idx (wr_bucket),
    .rd_idx   (wr_bucket),
    .rd_val   (dst_wr_addr)
  );

  ovf_relocator #(.NB(NB), .AW(AW), .DW(DW), .FD(FD)) u_move (
    .clk            (clk),
    .rst_n          (rst_n),
    .go             (move_go),
    .total_in       (total),
    .src_rd_req     (src_rd_req),
    .src_rd_addr    (src_rd_addr),
    .src_rd_ready   (src_rd_ready),
    .src_rsp_valid  (src_rsp_valid),
    .src_rsp_bucket (src_rsp_bucket),
    .src_rsp_data   (src_rsp_data),
    .wr_valid       (dst_wr_valid),
    .wr_bucket      (wr_bucket),
    .wr_data        (dst_wr_data),
    .wr_ready       (dst_wr_ready),
    .rd_fire        (rd_fire),
    .wr_fire        (wr_fire),
    .moved_all      (moved_all)
  );

  // R9: completion lasts exactly one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no traffic on the row ports once done is raised
  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !src_rd_req && !dst_wr_valid);

  // R10: a start during a run does not restart the counter pass
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start && (state == MG_MOVE || state == MG_FIN) |=> state != MG_SCAN);

  // R2: counter reads only happen in the offset pass
  a_r2_reads_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd_en |-> state == MG_SCAN);

  // R8: a stalled write holds address and data
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_valid && !dst_wr_ready |=> dst_wr_valid && $stable(dst_wr_addr) && $stable(dst_wr_data));

  // R4: back-to-back rows of one bucket get adjacent addresses
  a_r4_cursor_advance: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !(dst_wr_valid && wr_bucket == $past(wr_bucket)) ||
                dst_wr_addr == AW'($past(dst_wr_addr) + 1'b1));
endmodule

// File: tb/ovf_merge_engine_tb.sv
module ovf_merge_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int CW = 5;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int FD = 2;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done;
  logic cnt_rd_en;
  logic [BW-1:0] cnt_rd_addr;
  logic [CW-1:0] cnt_rd_data = '0;
  logic src_rd_req;
  logic [AW-1:0] src_rd_addr;
  logic src_rd_ready = 1'b1;
  logic src_rsp_valid = 1'b0;
  logic [BW-1:0] src_rsp_bucket = '0;
  logic [DW-1:0] src_rsp_data = '0;
  logic dst_wr_valid;
  logic [AW-1:0] dst_wr_addr;
  logic [DW-1:0] dst_wr_data;
  logic dst_wr_ready = 1'b1;

  ovf_merge_engine #(.NB(NB), .CW(CW), .AW(AW), .DW(DW), .FD(FD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .cnt_rd_en(cnt_rd_en), .cnt_rd_addr(cnt_rd_addr), .cnt_rd_data(cnt_rd_data),
    .src_rd_req(src_rd_req), .src_rd_addr(src_rd_addr), .src_rd_ready(src_rd_ready),
    .src_rsp_valid(src_rsp_valid), .src_rsp_bucket(src_rsp_bucket), .src_rsp_data(src_rsp_data),
    .dst_wr_valid(dst_wr_valid), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data),
    .dst_wr_ready(dst_wr_ready)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [AW+DW-1:0] exp_q [$];
  logic [BW-1:0] src_bkt [256];
  logic [DW-1:0] src_dat [256];
  logic [CW-1:0] cnt_mem [NB];
  int cnt_exp, rd_exp, done_cnt, both_cnt;
  bit full_ready = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // ready patterns, changed just after the rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src_rd_ready = full_ready | lfsr[0] | lfsr[3];
      dst_wr_ready = full_ready | lfsr[5];
    end
  end

  // counter memory model, one-cycle read latency (R2)
  initial begin
    bit pend = 1'b0;
    logic [BW-1:0] pa = '0;
    forever begin
      @(negedge clk);
      if (pend) cnt_rd_data = cnt_mem[pa];
      pend = cnt_rd_en;
      if (pend) begin
        pa = cnt_rd_addr;
        check(int'(cnt_rd_addr) == cnt_exp, "R2", "counter read address", int'(cnt_rd_addr), cnt_exp);
        cnt_exp++;
      end
    end
  end

  // source memory model, data one cycle after acceptance (R5)
  initial begin
    bit pend = 1'b0;
    logic [AW-1:0] pa = '0;
    forever begin
      @(negedge clk);
      src_rsp_valid = pend;
      if (pend) begin
        src_rsp_bucket = src_bkt[pa];
        src_rsp_data   = src_dat[pa];
      end
      pend = src_rd_req && src_rd_ready;
      if (pend) begin
        pa = src_rd_addr;
        check(int'(src_rd_addr) == rd_exp, "R5", "source read address", int'(src_rd_addr), rd_exp);
        rd_exp++;
      end
    end
  end

  // monitor: scoreboard pop and hold checks
  initial begin
    bit prev_done = 1'b0;
    bit prev_stall = 1'b0;
    logic [AW+DW-1:0] prev_item = '0;
    logic [AW+DW-1:0] e;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_done = 1'b0; prev_stall = 1'b0;
      end else begin
        if (prev_stall) begin
          check(dst_wr_valid === 1'b1, "R8", "write dropped while stalled", int'(dst_wr_valid), 1);
          check({dst_wr_addr, dst_wr_data} == prev_item, "R8", "write changed while stalled",
                int'(dst_wr_addr), int'(prev_item[AW+DW-1:DW]));
        end
        prev_stall = dst_wr_valid && !dst_wr_ready;
        prev_item  = {dst_wr_addr, dst_wr_data};
        if (dst_wr_valid && dst_wr_ready) begin
          if (src_rd_req && src_rd_ready) both_cnt++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected write", int'(dst_wr_addr), -1);
          end else begin
            e = exp_q.pop_front();
            check(dst_wr_addr == e[AW+DW-1:DW], "R3/R4", "write address",
                  int'(dst_wr_addr), int'(e[AW+DW-1:DW]));
            check(dst_wr_data == e[DW-1:0], "R6", "write data",
                  int'(dst_wr_data), int'(e[DW-1:0]));
          end
        end
        if (done) begin
          check(!prev_done, "R9", "done longer than one cycle", 2, 1);
          check(exp_q.size() == 0, "R9", "rows left at done", exp_q.size(), 0);
          done_cnt++;
        end
        prev_done = done;
      end
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  // kind 0: spread over buckets 0..6 (bucket 7 empty); kind 1: long run of bucket 3 then mix
  task automatic run_case(input int n, input int kind, input bit all_ready,
                          input bit restart, input int tag);
    int cnt [NB];
    int off [NB];
    int run_sum;
    int wait_cyc;
    for (int b = 0; b < NB; b++) cnt[b] = 0;
    for (int i = 0; i < n; i++) begin
      int b;
      if (kind == 0) b = (i * 3) % 7;
      else           b = (i < 12) ? 3 : ((i % 3) * 2 + ((i % 5 == 0) ? 7 - ((i % 3) * 2) : 0));
      src_bkt[i] = BW'(b);
      src_dat[i] = DW'(16'hA000 + i * 7 + tag * 131);
      cnt[b]++;
    end
    run_sum = 0;
    for (int b = 0; b < NB; b++) begin
      off[b] = run_sum;
      run_sum += cnt[b];
      cnt_mem[b] = CW'(cnt[b]);
    end
    for (int i = 0; i < n; i++) begin
      int b = int'(src_bkt[i]);
      exp_q.push_back({AW'(off[b]), src_dat[i]});
      off[b]++;
    end
    cnt_exp = 0; rd_exp = 0; done_cnt = 0;
    full_ready = all_ready;
    pulse_start();
    if (restart) begin
      repeat (8) @(posedge clk);
      pulse_start();
    end
    wait_cyc = 0;
    while (done_cnt == 0 && wait_cyc < 5000) begin
      @(posedge clk); wait_cyc++;
    end
    check(done_cnt != 0, "R9", "done never seen", 0, 1);
    repeat (6) @(negedge clk);
    check(done_cnt == 1, restart ? "R10" : "R9", "done pulse count", done_cnt, 1);
    check(cnt_exp == NB, "R2", "counter reads per run", cnt_exp, NB);
    check(rd_exp == n, "R5", "source reads per run", rd_exp, n);
    check(exp_q.size() == 0, "R6", "rows not written", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle outputs during and right after reset
    check(!done && !cnt_rd_en && !src_rd_req && !dst_wr_valid, "R1", "outputs in reset", 1, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!done && !cnt_rd_en && !src_rd_req && !dst_wr_valid, "R1", "outputs after reset", 1, 0);

    both_cnt = 0;
    run_case(30, 0, 1'b1, 1'b0, 1);       // R3 R6, all ports ready
    check(both_cnt > 0, "R7", "concurrent read and write", both_cnt, 1);
    run_case(40, 1, 1'b0, 1'b0, 2);       // R4 R8, back-to-back bucket under stalls
    run_case(0, 0, 1'b0, 1'b0, 3);        // R9 all counts zero
    run_case(25, 0, 1'b0, 1'b1, 4);       // R10 start during a run
    run_case(60, 1, 1'b1, 1'b0, 5);       // R3 R4 longer mix

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule